// File: doc/BRIEF.md
# Counting Semaphore with FIFO Wait Queue

This block arbitrates a pool of interchangeable units among a fixed set of requesters. It holds a count of free units, which reset loads from a parameter. It also holds a first-in, first-out queue of the requesters that are blocked. An acquire request carries the requester's index. If a unit is free, the requester gets one at once. If none is free, the requester joins the tail of the queue. A release either gives its unit directly to the requester that has waited longest, or returns the unit to the pool.

A grant is a one-cycle pulse on the output bit for the chosen requester. It appears in the cycle after the request that caused it. The current count and the number of waiters are always visible. When the queue is full, acquire requests are stalled through a ready signal. A parameter switches the block into binary mode. In that mode the count is 0 or 1 and starts at 1, so an acquire behaves as a lock take and a release as a lock drop. The block takes an asynchronous active-low reset, and its release is resynchronised to the clock inside the block.

Top module: `wait_sem`

## Requirements
- R1: One cycle after the internal reset release, count equals INIT_CNT (1 in binary mode), q_occ is 0, grant is all zero and acq_ready is 1.
- R2: An accepted acquire that finds a free unit pulses grant bit acq_id (bit i belongs to requester i) in the next cycle and lowers count by one.
- R3: An accepted acquire that finds count at zero gives no grant, leaves count at zero and raises q_occ by one.
- R4: A release while the queue holds waiters pops the oldest one and pulses its grant bit in the next cycle; count stays zero and q_occ drops by one.
- R5: A release with an empty queue raises count by one, saturating at 2**CNT_W-1 (binary mode: at 1).
- R6: Waiters are granted in the order in which their acquires were accepted.
- R7: When an acquire and a release arrive in the same cycle, the release is applied first and the acquire then sees the resulting count and queue.
- R8: Whenever count is nonzero, q_occ is zero.
- R9: While q_occ equals QDEPTH, acq_ready is 0 and an asserted acq_valid has no effect on count, q_occ or grant.
- R10: In binary mode the count resets to 1 and never exceeds 1; a release while count is 1 leaves it at 1.
- R11: At most one grant bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acq_valid | input | 1 | Acquire request this cycle |
| acq_id | input | ID_W | Index of the requester making the acquire |
| acq_ready | output | 1 | Acquire accepted when high (queue not full) |
| rel_valid | input | 1 | Release of one unit this cycle |
| grant | output | N_REQ | One-cycle grant pulse, one bit per requester |
| count | output | CNT_W | Free units currently held |
| q_occ | output | OCC_W | Number of queued waiters |

## Verification
The assertions assume two things about the inputs. The first is that acq_id always names an existing requester. The second is that the queue depth is large enough for the traffic, so an acquire is only ever pushed past a full queue through the stall path. The stimulus draws requester indices only from 0 to N_REQ-1. It still drives acq_valid freely while acq_ready is low, so that the block's refusal can be observed at the ports. The random phases switch between acquire-heavy and release-heavy mixes. This drives the queue to full and back to empty and makes the count saturate. Directed sequences cover the hand-off order, same-cycle acquire and release, and binary mode.

// File: rtl/wait_sem_pkg.sv
package wait_sem_pkg;
  function automatic int unsigned sem_clog2(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((32'd1 << r) < v) r++;
    return (r == 0) ? 1 : r;
  endfunction

  typedef enum logic [1:0] {
    SEM_IDLE  = 2'd0,
    SEM_TAKE  = 2'd1,
    SEM_BLOCK = 2'd2
  } acq_kind_e;
endpackage

// File: rtl/sem_rst_sync.sv
module sem_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/sem_count.sv
module sem_count #(
  parameter int unsigned CNT_W = 3,
  parameter int unsigned INIT  = 2,
  parameter int unsigned CMAX  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] INIT_V = CNT_W'(INIT);
  localparam logic [CNT_W-1:0] MAX_V  = CNT_W'(CMAX);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mid_c;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    mid_c = cnt_q;
    if (inc && (cnt_q != MAX_V)) mid_c = cnt_q + CNT_W'(1);
    cnt_d = mid_c;
    if (dec) cnt_d = mid_c - CNT_W'(1);
    cnt_en = inc | dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= INIT_V;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MAX_V);
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc) |-> (cnt_q != '0));
endmodule

// File: rtl/sem_fifo.sv
module sem_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic [wait_sem_pkg::sem_clog2(DEPTH+1)-1:0] occ,
  output logic         full,
  output logic         empty
);
  localparam int unsigned PTR_W = wait_sem_pkg::sem_clog2(DEPTH);
  localparam int unsigned OCC_W = wait_sem_pkg::sem_clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);
  localparam logic [OCC_W-1:0] FULL_V = OCC_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q, wr_d, rd_d;
  logic [OCC_W-1:0] occ_q, occ_d;
  logic             st_en;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    occ_d = occ_q;
    if (push) wr_d = (wr_q == LAST) ? '0 : wr_q + PTR_W'(1);
    if (pop)  rd_d = (rd_q == LAST) ? '0 : rd_q + PTR_W'(1);
    if (push && !pop) occ_d = occ_q + OCC_W'(1);
    if (pop && !push) occ_d = occ_q - OCC_W'(1);
    st_en = push | pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
    end else if (st_en) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      occ_q <= occ_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_data;
  end

  assign head  = mem[rd_q];
  assign occ   = occ_q;
  assign full  = (occ_q == FULL_V);
  assign empty = (occ_q == '0);

  assert_no_push_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  assert_no_pop_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
endmodule

// File: rtl/sem_grant.sv
module sem_grant #(
  parameter int unsigned N_REQ = 4,
  parameter int unsigned ID_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [ID_W-1:0]  id,
  output logic [N_REQ-1:0] grant
);
  logic [N_REQ-1:0] g_q;
  logic [N_REQ-1:0] g_d;

  for (genvar i = 0; i < N_REQ; i++) begin : g_bit
    always_comb g_d[i] = fire && (id == ID_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) g_q[i] <= 1'b0;
      else        g_q[i] <= g_d[i];
    end
  end

  assign grant = g_q;

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> (g_q == '0));
endmodule

// File: rtl/wait_sem.sv
module wait_sem #(
  parameter int unsigned N_REQ    = 4,
  parameter int unsigned QDEPTH   = 4,
  parameter int unsigned CNT_W    = 3,
  parameter int unsigned INIT_CNT = 2,
  parameter bit          BINARY   = 1'b0,
  localparam int unsigned ID_W  = wait_sem_pkg::sem_clog2(N_REQ),
  localparam int unsigned OCC_W = wait_sem_pkg::sem_clog2(QDEPTH+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acq_valid,
  input  logic [ID_W-1:0]  acq_id,
  output logic             acq_ready,
  input  logic             rel_valid,
  output logic [N_REQ-1:0] grant,
  output logic [CNT_W-1:0] count,
  output logic [OCC_W-1:0] q_occ
);
  import wait_sem_pkg::*;

  localparam int unsigned CMAX  = BINARY ? 1 : ((1 << CNT_W) - 1);
  localparam int unsigned INITV = BINARY ? 1 : INIT_CNT;

  logic            rst_i_n;
  logic            q_full, q_empty;
  logic [ID_W-1:0] q_head;
  logic            acq_fire, wake, rel_inc, avail_after_rel;
  logic            take, block;
  logic            g_fire;
  logic [ID_W-1:0] g_id;
  acq_kind_e       kind;

  sem_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // Release is resolved before the acquire of the same cycle.
  always_comb begin
    acq_fire        = acq_valid & acq_ready;
    wake            = rel_valid & ~q_empty;
    rel_inc         = rel_valid & q_empty;
    avail_after_rel = (count != '0) | rel_inc;
    kind = SEM_IDLE;
    if (acq_fire) kind = avail_after_rel ? SEM_TAKE : SEM_BLOCK;
    take   = (kind == SEM_TAKE);
    block  = (kind == SEM_BLOCK);
    g_fire = wake | take;
    g_id   = wake ? q_head : acq_id;
  end

  assign acq_ready = ~q_full;

  sem_count #(
    .CNT_W (CNT_W),
    .INIT  (INITV),
    .CMAX  (CMAX)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_i_n),
    .inc   (rel_inc),
    .dec   (take),
    .count (count)
  );

  sem_fifo #(
    .DEPTH (QDEPTH),
    .W     (ID_W)
  ) u_q (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .push      (block),
    .push_data (acq_id),
    .pop       (wake),
    .head      (q_head),
    .occ       (q_occ),
    .full      (q_full),
    .empty     (q_empty)
  );

  sem_grant #(
    .N_REQ (N_REQ),
    .ID_W  (ID_W)
  ) u_gnt (
    .clk   (clk),
    .rst_n (rst_i_n),
    .fire  (g_fire),
    .id    (g_id),
    .grant (grant)
  );

  assert_q_empty_when_pos_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (count != '0) |-> (q_occ == '0));
  assert_one_grant_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(grant));
  assert_full_stall_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (q_occ == OCC_W'(QDEPTH)) |-> !acq_ready);
  assert_handoff_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rel_valid && q_occ != '0) |=> (count == '0 && grant != '0));
  assert_block_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (acq_valid && acq_ready && count == '0 && !rel_valid)
      |=> (q_occ == $past(q_occ) + OCC_W'(1) && grant == '0));
  assert_bin_limit_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    BINARY |-> (count <= CNT_W'(1)));
endmodule

// File: tb/tb_wait_sem.sv
`timescale 1ns/1ps
module tb_wait_sem;
  localparam int N  = 4;
  localparam int QD = 4;
  localparam int CW = 3;
  localparam int CMAX = 7;
  localparam int IW = 2;
  localparam int OW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic acq_valid, rel_valid, acq_ready;
  logic [IW-1:0] acq_id;
  logic [N-1:0]  grant;
  logic [CW-1:0] count;
  logic [OW-1:0] q_occ;

  logic b_acq_valid, b_rel_valid, b_acq_ready;
  logic [IW-1:0] b_acq_id;
  logic [N-1:0]  b_grant;
  logic [CW-1:0] b_count;
  logic [OW-1:0] b_q_occ;

  int checks = 0;
  int errors = 0;
  int cm;
  int qm[$];
  bit done = 0;

  always #5 clk = ~clk;

  wait_sem #(.N_REQ(N), .QDEPTH(QD), .CNT_W(CW), .INIT_CNT(2), .BINARY(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .acq_valid(acq_valid), .acq_id(acq_id),
    .acq_ready(acq_ready), .rel_valid(rel_valid), .grant(grant),
    .count(count), .q_occ(q_occ));

  wait_sem #(.N_REQ(N), .QDEPTH(QD), .CNT_W(CW), .INIT_CNT(2), .BINARY(1'b1)) dut_bin (
    .clk(clk), .rst_n(rst_n), .acq_valid(b_acq_valid), .acq_id(b_acq_id),
    .acq_ready(b_acq_ready), .rel_valid(b_rel_valid), .grant(b_grant),
    .count(b_count), .q_occ(b_q_occ));

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_grant(input int id);
    return (id < 0) ? 0 : (1 << id);
  endfunction

  // Reference model step: release first, then acquire (R7).
  task automatic step(input bit pv, input int pid, input bit vv, input string tag_in);
    int    eg;
    bit    er;
    string tag;
    er = (qm.size() < QD);
    tag = tag_in;
    if (tag == "") begin
      if (pv && !er)                     tag = "R9";
      else if (pv && vv)                 tag = "R7";
      else if (vv && qm.size() > 0)      tag = "R4";
      else if (vv)                       tag = "R5";
      else if (pv && cm > 0)             tag = "R2";
      else if (pv)                       tag = "R3";
      else                               tag = "R11";
    end
    chk(acq_ready == er, tag, "acq_ready", acq_ready, er);
    acq_valid = pv; acq_id = IW'(pid); rel_valid = vv;
    eg = -1;
    if (vv) begin
      if (qm.size() > 0) eg = qm.pop_front();
      else if (cm < CMAX) cm++;
    end
    if (pv && er) begin
      if (cm > 0) begin cm--; eg = pid; end
      else qm.push_back(pid);
    end
    @(posedge clk); #1;
    acq_valid = 0; rel_valid = 0;
    chk(grant == N'(exp_grant(eg)), tag, "grant", grant, exp_grant(eg));
    chk(count == CW'(cm), tag, "count", count, cm);
    chk(q_occ == OW'(qm.size()), tag, "q_occ", q_occ, qm.size());
    chk(!(count != 0 && q_occ != 0), "R8", "count_with_waiters", q_occ, 0);
  endtask

  task automatic bstep(input bit pv, input int pid, input bit vv,
                       input int eg, input int ec, input int eo);
    b_acq_valid = pv; b_acq_id = IW'(pid); b_rel_valid = vv;
    @(posedge clk); #1;
    b_acq_valid = 0; b_rel_valid = 0;
    chk(b_grant == N'(exp_grant(eg)), "R10", "bin grant", b_grant, exp_grant(eg));
    chk(b_count == CW'(ec), "R10", "bin count", b_count, ec);
    chk(b_q_occ == OW'(eo), "R10", "bin q_occ", b_q_occ, eo);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    rst_n = 0; acq_valid = 0; rel_valid = 0; acq_id = 0;
    b_acq_valid = 0; b_rel_valid = 0; b_acq_id = 0;
    sd = $urandom(32'd4711);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(count == 2, "R1", "count", count, 2);
    chk(q_occ == 0, "R1", "q_occ", q_occ, 0);
    chk(grant == 0, "R1", "grant", grant, 0);
    chk(acq_ready == 1, "R1", "acq_ready", acq_ready, 1);
    chk(b_count == 1, "R1", "bin count", b_count, 1);
    cm = 2;

    // R2 immediate takes, then R3 blocking
    step(1, 0, 0, "R2");
    step(1, 1, 0, "R2");
    step(1, 3, 0, "R3");
    step(1, 1, 0, "R3");
    step(1, 2, 0, "R3");
    // R6 oldest waiter first: 3, 1, 2
    step(0, 0, 1, "R6");
    step(0, 0, 1, "R6");
    step(1, 0, 1, "R7"); // release hands to 2, acquire of 0 blocks
    step(0, 0, 1, "R4");
    // R7 with empty queue and zero count: release then immediate take
    step(1, 2, 1, "R7");
    // R5 saturation
    for (int i = 0; i < 9; i++) step(0, 0, 1, "R5");
    // drain and fill queue to full, R9 stall
    for (int i = 0; i < 7; i++) step(1, i % N, 0, "R2");
    for (int i = 0; i < QD; i++) step(1, (i + 1) % N, 0, "R3");
    step(1, 0, 0, "R9");
    step(1, 3, 0, "R9");
    for (int i = 0; i < QD; i++) step(0, 0, 1, "R6");

    // random phases
    for (int i = 0; i < 400; i++) begin
      bit pv, vv;
      pv = ($urandom % 2) == 1;
      if ((i / 100) % 2 == 0) vv = ($urandom % 4) == 0;
      else                    vv = ($urandom % 4) != 0;
      step(pv, int'($urandom % N), vv, "");
    end

    // R10 binary mode
    bstep(1, 0, 0, 0, 0, 0);
    bstep(1, 1, 0, -1, 0, 1);
    bstep(0, 0, 1, 1, 0, 0);
    bstep(0, 0, 1, -1, 1, 0);
    bstep(0, 0, 1, -1, 1, 0);
    bstep(1, 2, 1, 2, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule